// File: doc/BRIEF.md
# Bus Cycle Wait-State Terminator

This block sets the length of each data beat of one external bus access made through a chip-select. When a cycle is accepted, it latches a wait-state count and a few per-cycle options. It then counts clock cycles, one per wait state. When the count is used up, it raises an internal transfer acknowledge. It can also leave the end of the beat to the external device, which returns an acknowledge of its own. That external acknowledge takes priority: it ends the beat at once, even while the countdown is still running.

For burst accesses the block repeats the timing for each beat. It reloads the wait count at the start of each beat. Between beats that it terminates itself, it pulses an address-increment strobe. After the final beat it flags the end of the cycle for one clock. It rejects a configuration that could never end: auto-acknowledge off while the external acknowledge input is disabled. In that case it raises an error strobe and does not start the cycle. Address decode, data lane steering and arbitration are handled by neighbouring logic.

Top module: `bus_wait_term`

## Requirements
- R1: After reset, `busy_o`, `int_ack_o`, `beat_done_o`, `addr_inc_o`, `cycle_end_o` and `cfg_err_o` are all low.
- R2: A `start_i` sampled high on a rising edge while idle starts a cycle. Counting the clock cycles after that edge as 1, 2, ..., with auto-acknowledge on and no external acknowledge, `int_ack_o` and `beat_done_o` are high for one clock in cycle `ws_i`+1 only. `ws_i` = 0 gives no wait states and 63 gives 63 wait states.
- R3: With auto-acknowledge off, `int_ack_o` never rises. A beat ends, with `beat_done_o` high, only in the cycle in which `ext_ack_i` is high, whatever the wait-state value.
- R4: With the external acknowledge input enabled, an `ext_ack_i` high during an active beat ends that beat in the same cycle. This holds even before the countdown has expired. In that cycle `int_ack_o` stays low.
- R5: `ext_ack_i` has no effect while no cycle is active, or when `ext_ack_en_i` was low at cycle start.
- R6: A burst (`burst_i` = 1) has `beats_i`+1 beats, and a non-burst access has exactly one beat. The wait count reloads at every beat, so each beat that ends internally is `ws_i`+1 cycles long.
- R7: `addr_inc_o` is high together with `int_ack_o` for each internally ended burst beat except the final one. It stays low for externally ended beats and for non-burst accesses.
- R8: `cycle_end_o` is high for exactly one clock, in the cycle after the final beat's `beat_done_o`. `busy_o` is low in that cycle.
- R9: A `start_i` while idle with `auto_ack_en_i` = 0 and `ext_ack_en_i` = 0 starts no cycle. `cfg_err_o` goes high for one clock in the following cycle.
- R10: `start_i` and the configuration inputs are ignored while a cycle is active. Timing follows the values latched at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a cycle (chip-select asserts) |
| ws_i | input | WS_W (6) | Wait states per beat |
| auto_ack_en_i | input | 1 | 1: generate the internal acknowledge after the wait states |
| ext_ack_en_i | input | 1 | 1: the external acknowledge input is in use |
| burst_i | input | 1 | 1: burst access |
| beats_i | input | BEAT_W (3) | Burst beats minus one |
| ext_ack_i | input | 1 | Acknowledge from the external device |
| busy_o | output | 1 | A cycle is in its data phase |
| int_ack_o | output | 1 | Internal transfer acknowledge |
| beat_done_o | output | 1 | Current beat terminates at this edge |
| addr_inc_o | output | 1 | Advance the address for the next burst beat |
| cycle_end_o | output | 1 | One-clock strobe after the final beat |
| cfg_err_o | output | 1 | One-clock strobe for a rejected start |

## Verification
Some rules are checked by the assertions on every cycle. These are: no acknowledge or strobe while idle, the internal acknowledge yielding to an external one, the address strobe only accompanying an internal acknowledge, the counter holding at expiry, and the cycle-end strobe following a final beat for a single clock. The exact cycle in which each beat ends can only be shown by the bench's sweeps. The same goes for the reload of the count on every burst beat, the number of beats, and the rejection of an unending configuration. Those sweeps cover every wait-state value, and burst lengths combined with early external acknowledges.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

   typedef enum logic [0:0] {
      ST_IDLE   = 1'b0,
      ST_ACTIVE = 1'b1
   } bwt_state_e;

   typedef struct packed {
      logic auto_ack;
      logic ext_en;
      logic burst;
   } bwt_opts_t;

endpackage

// File: rtl/bwt_wait_ctr.sv
module bwt_wait_ctr #(
   parameter int WS_W     = 6,
   parameter bit COUNT_UP = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [WS_W-1:0] ws_in,
   input  logic            reload,
   input  logic            run,
   output logic            expired
);

   localparam logic [WS_W-1:0] ZERO = '0;
   localparam logic [WS_W-1:0] ONE  = {{(WS_W-1){1'b0}}, 1'b1};

   if (WS_W < 1 || WS_W > 16) begin : g_bad_ws_w
      $error("bwt_wait_ctr: WS_W must lie in 1..16");
   end

   logic [WS_W-1:0] ws_q;
   logic [WS_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ws_q <= ZERO;
      else if (start) ws_q <= ws_in;
   end

   if (COUNT_UP) begin : g_up
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     cnt_q <= ZERO;
         else if (start || reload)       cnt_q <= ZERO;
         else if (run && cnt_q != ws_q)  cnt_q <= cnt_q + ONE;
      end
      assign expired = (cnt_q == ws_q);
   end else begin : g_down
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     cnt_q <= ZERO;
         else if (start)                 cnt_q <= ws_in;
         else if (reload)                cnt_q <= ws_q;
         else if (run && cnt_q != ZERO)  cnt_q <= cnt_q - ONE;
      end
      assign expired = (cnt_q == ZERO);
   end

   // R2: once expired, the count stays expired until a new load
   assert_ctr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && expired && !start && !reload) |=> expired);

endmodule

// File: rtl/bwt_beat_ctr.sv
module bwt_beat_ctr #(
   parameter int BEAT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              burst,
   input  logic [BEAT_W-1:0] beats,
   input  logic              beat_done,
   output logic              last
);

   localparam logic [BEAT_W-1:0] ZERO = '0;
   localparam logic [BEAT_W-1:0] ONE  = {{(BEAT_W-1){1'b0}}, 1'b1};

   if (BEAT_W < 1 || BEAT_W > 8) begin : g_bad_beat_w
      $error("bwt_beat_ctr: BEAT_W must lie in 1..8");
   end

   logic [BEAT_W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         rem_q <= ZERO;
      else if (start)                     rem_q <= burst ? beats : ZERO;
      else if (beat_done && rem_q != ZERO) rem_q <= rem_q - ONE;
   end

   assign last = (rem_q == ZERO);

   // R6: a beat ending with beats remaining lowers the remainder by one
   assert_beat_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_done && !start && !last) |=> (rem_q == $past(rem_q) - ONE));

endmodule

// File: rtl/bus_wait_term.sv
module bus_wait_term
   import bwt_pkg::*;
#(
   parameter int WS_W     = 6,
   parameter int BEAT_W   = 3,
   parameter bit COUNT_UP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [WS_W-1:0]   ws_i,
   input  logic              auto_ack_en_i,
   input  logic              ext_ack_en_i,
   input  logic              burst_i,
   input  logic [BEAT_W-1:0] beats_i,
   input  logic              ext_ack_i,
   output logic              busy_o,
   output logic              int_ack_o,
   output logic              beat_done_o,
   output logic              addr_inc_o,
   output logic              cycle_end_o,
   output logic              cfg_err_o
);

   bwt_state_e state_q;
   bwt_opts_t  opts_q;
   logic       end_q;
   logic       err_q;
   logic       idle;
   logic       cfg_bad;
   logic       accept;
   logic       expired;
   logic       last_beat;
   logic       ext_hit;
   logic       int_hit;
   logic       done;

   assign idle    = (state_q == ST_IDLE);
   assign cfg_bad = !auto_ack_en_i && !ext_ack_en_i;
   assign accept  = start_i && idle && !cfg_bad;

   assign ext_hit = !idle && opts_q.ext_en && ext_ack_i;
   assign int_hit = !idle && opts_q.auto_ack && expired && !ext_hit;
   assign done    = ext_hit || int_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         opts_q  <= '0;
         end_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         end_q <= done && last_beat;
         err_q <= start_i && idle && cfg_bad;
         if (accept) begin
            state_q        <= ST_ACTIVE;
            opts_q.auto_ack <= auto_ack_en_i;
            opts_q.ext_en   <= ext_ack_en_i;
            opts_q.burst    <= burst_i;
         end else if (done && last_beat) begin
            state_q <= ST_IDLE;
         end
      end
   end

   bwt_wait_ctr #(
      .WS_W     (WS_W),
      .COUNT_UP (COUNT_UP)
   ) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (accept),
      .ws_in   (ws_i),
      .reload  (done && !last_beat),
      .run     (!idle),
      .expired (expired)
   );

   bwt_beat_ctr #(
      .BEAT_W (BEAT_W)
   ) u_beats (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .burst     (burst_i),
      .beats     (beats_i),
      .beat_done (done),
      .last      (last_beat)
   );

   assign busy_o      = !idle;
   assign int_ack_o   = int_hit;
   assign beat_done_o = done;
   assign addr_inc_o  = int_hit && opts_q.burst && !last_beat;
   assign cycle_end_o = end_q;
   assign cfg_err_o   = err_q;

   // R5: nothing is acknowledged while idle
   assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!beat_done_o && !int_ack_o && !addr_inc_o));

   // R4: an external acknowledge during a beat wins over the internal one
   assert_ext_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && opts_q.ext_en && ext_ack_i) |-> (beat_done_o && !int_ack_o));

   // R3: auto-acknowledge off never yields an internal acknowledge
   assert_no_auto_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !opts_q.auto_ack) |-> !int_ack_o);

   // R7: address advance only accompanies an internal acknowledge
   assert_inc_with_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      addr_inc_o |-> (int_ack_o && beat_done_o));

   // R8: cycle end follows a beat termination and lasts one clock
   assert_end_after_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_end_o |-> ($past(beat_done_o) && !busy_o));
   assert_end_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_end_o |=> !cycle_end_o);

   // R9: a rejected start never brings the block out of idle
   assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err_o |-> !$past(accept));

endmodule

// File: tb/bus_wait_term_test.sv
module bus_wait_term_test;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [5:0] ws_i = '0;
   logic       auto_ack_en_i = 1'b0;
   logic       ext_ack_en_i = 1'b0;
   logic       burst_i = 1'b0;
   logic [2:0] beats_i = '0;
   logic       ext_ack_i = 1'b0;
   logic       busy_o, int_ack_o, beat_done_o, addr_inc_o, cycle_end_o, cfg_err_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_wait_term uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .ws_i(ws_i),
      .auto_ack_en_i(auto_ack_en_i), .ext_ack_en_i(ext_ack_en_i),
      .burst_i(burst_i), .beats_i(beats_i), .ext_ack_i(ext_ack_i),
      .busy_o(busy_o), .int_ack_o(int_ack_o), .beat_done_o(beat_done_o),
      .addr_inc_o(addr_inc_o), .cycle_end_o(cycle_end_o), .cfg_err_o(cfg_err_o)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0b exp=%0b", req, act, exp);
      end
   endtask

   // One complete access; ext_at is the cycle within each beat carrying ext_ack_i (0 = never)
   task automatic run_cycle(input int ws, input bit auto_en, input bit ext_en,
                            input bit brst, input int beats, input int ext_at);
      int nb = brst ? beats + 1 : 1;
      @(negedge clk);
      start_i = 1'b1; ws_i = 6'(ws); auto_ack_en_i = auto_en;
      ext_ack_en_i = ext_en; burst_i = brst; beats_i = 3'(beats); ext_ack_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      for (int b = 0; b < nb; b++) begin
         bit fin = 1'b0;
         for (int k = 1; k <= 70 && !fin; k++) begin
            bit e_term, i_term;
            ext_ack_i = (ext_at == k);
            #1;
            e_term = ext_en && (ext_at == k);
            i_term = auto_en && (k == ws + 1) && !e_term;
            chk("R2 int_ack_o timing", int_ack_o, i_term);
            chk("R4 beat_done_o timing", beat_done_o, e_term || i_term);
            chk("R7 addr_inc_o", addr_inc_o, i_term && brst && (b < nb - 1));
            chk("R6 busy_o during beat", busy_o, 1'b1);
            fin = e_term || i_term;
            @(negedge clk);
            ext_ack_i = 1'b0;
         end
      end
      #1;
      chk("R8 cycle_end_o raised", cycle_end_o, 1'b1);
      chk("R8 busy_o low at end", busy_o, 1'b0);
      @(negedge clk);
      #1;
      chk("R8 cycle_end_o single", cycle_end_o, 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD*2 + 2);
      chk("R1 busy_o reset", busy_o, 1'b0);
      chk("R1 int_ack_o reset", int_ack_o, 1'b0);
      chk("R1 beat_done_o reset", beat_done_o, 1'b0);
      chk("R1 addr_inc_o reset", addr_inc_o, 1'b0);
      chk("R1 cycle_end_o reset", cycle_end_o, 1'b0);
      chk("R1 cfg_err_o reset", cfg_err_o, 1'b0);
      rst_n = 1'b1;

      // R2: every wait-state value, single beat, internal termination
      for (int w = 0; w < 64; w++) run_cycle(w, 1'b1, 1'b0, 1'b0, 0, 0);
      // R6 / R7: bursts, counter reload on each beat
      for (int w = 0; w < 8; w++)
         for (int n = 0; n < 4; n++) run_cycle(w, 1'b1, 1'b1, 1'b1, n, 0);
      // burst bit low ignores beats_i (R6)
      run_cycle(2, 1'b1, 1'b0, 1'b0, 5, 0);
      // R3: auto-acknowledge off, external termination only
      for (int w = 0; w < 64; w += 9)
         for (int e = 1; e < 6; e++) run_cycle(w, 1'b0, 1'b1, 1'b0, 0, e);
      run_cycle(1, 1'b0, 1'b1, 1'b1, 2, 4);
      // R4: external acknowledge cuts the countdown short, incl. bursts (R7 no inc)
      for (int e = 1; e <= 11; e++) run_cycle(10, 1'b1, 1'b1, 1'b0, 0, e);
      run_cycle(6, 1'b1, 1'b1, 1'b1, 3, 3);
      // R5: external acknowledge with input disabled has no effect
      run_cycle(4, 1'b1, 1'b0, 1'b0, 0, 2);
      run_cycle(4, 1'b1, 1'b0, 1'b1, 1, 1);

      // R5: external acknowledge while idle
      @(negedge clk);
      ext_ack_en_i = 1'b1; auto_ack_en_i = 1'b1; ext_ack_i = 1'b1;
      #1;
      chk("R5 idle beat_done_o", beat_done_o, 1'b0);
      chk("R5 idle int_ack_o", int_ack_o, 1'b0);
      @(negedge clk);
      ext_ack_i = 1'b0;
      #1;
      chk("R5 idle busy_o", busy_o, 1'b0);
      chk("R5 idle cycle_end_o", cycle_end_o, 1'b0);

      // R9: unending configuration is rejected
      @(negedge clk);
      start_i = 1'b1; auto_ack_en_i = 1'b0; ext_ack_en_i = 1'b0; ws_i = 6'd0;
      @(negedge clk);
      start_i = 1'b0;
      #1;
      chk("R9 cfg_err_o raised", cfg_err_o, 1'b1);
      chk("R9 busy_o stays low", busy_o, 1'b0);
      chk("R9 no beat_done_o", beat_done_o, 1'b0);
      @(negedge clk);
      #1;
      chk("R9 cfg_err_o single", cfg_err_o, 1'b0);
      chk("R9 still idle", busy_o, 1'b0);

      // R10: a second start with new settings during a cycle is ignored
      @(negedge clk);
      start_i = 1'b1; ws_i = 6'd5; auto_ack_en_i = 1'b1; ext_ack_en_i = 1'b0;
      burst_i = 1'b0; beats_i = '0;
      @(negedge clk);
      start_i = 1'b0;
      for (int k = 1; k <= 6; k++) begin
         if (k == 2) begin
            start_i = 1'b1; ws_i = 6'd0; burst_i = 1'b1; beats_i = 3'd3;
         end else begin
            start_i = 1'b0;
         end
         #1;
         chk("R10 int_ack_o keeps latched ws", int_ack_o, k == 6);
         chk("R10 addr_inc_o keeps latched burst", addr_inc_o, 1'b0);
         @(negedge clk);
      end
      start_i = 1'b0;
      #1;
      chk("R10 cycle_end_o after single beat", cycle_end_o, 1'b1);
      chk("R10 busy_o low", busy_o, 1'b0);

      @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule